// File: doc/BRIEF.md
# DLL Lock Capture Sequencer

This block brings a memory PHY delay-locked loop out of reset and then pins it to the delay it found. After reset it writes a fixed sequence into two PHY control-register images. The main image first gets the parameter setting. The auxiliary image then gets a low-power DDR setting. The main image next gets the DLL-enable bit and, last, the DLL-start bit. The block then polls a lock-status word from the PHY, one sample per clock.

Once every lock indication in the status word is set, the block takes the measured delay code out of the status word. It moves the code into the forced-value field of the main control image, together with the force setting, so the DLL stops tracking and holds that delay. A done flag follows. If lock does not arrive within a parameterised number of samples, the block raises a timeout flag and stops in that state. The status word crosses clock domains through a two-flop synchronizer before any decision is taken.

Edges are counted from the first rising clock edge after reset release, which is edge 1.

Top module: `dll_lock_seq`

## Requirements
- R1: While reset is asserted, both control images read 0 and the done and timeout flags are low.
- R2: At edge 1 the main image becomes 0x00101000, the parameter-only word.
- R3: At edge 2 the auxiliary image becomes 0x00000086. It never takes any value other than 0 or 0x86.
- R4: At edge 3 the main image becomes 0x00101002. Bit 1 is the DLL-enable bit.
- R5: At edge 4 the main image becomes 0x00101003. Bit 0 is the DLL-start bit.
- R6: Lock is recognised only when status bits [2:0] are all 1. Any other pattern keeps the block polling. The status present before edge n is judged at edge n+2, and judging starts at edge 5.
- R7: On lock, the main image becomes ((status AND 0x3FC0) shifted left by 18) OR 0x00101003. The delay code in status bits [13:6] therefore lands in bits [31:24]. No other status bit affects the word.
- R8: The done flag rises one edge after the forced word is written and stays high until reset. From then on the main image does not change, whatever the status does.
- R9: If no lock is seen in LOCK_LIMIT consecutive samples, the timeout flag rises at edge LOCK_LIMIT+4. It stays high, done stays low, and the main image stays 0x00101003.
- R10: A lock seen on the last allowed sample, at edge LOCK_LIMIT+4, counts as lock and raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_status | input | STAT_W | PHY lock-status word, asynchronous to clk |
| ctl0_img | output | 32 | Main PHY control-register image |
| ctl1_img | output | 32 | Auxiliary PHY control-register image |
| done | output | 1 | Delay captured and forced |
| timeout_err | output | 1 | Lock not reached within LOCK_LIMIT samples |

## Verification
Lock recognition and the expiry of the wait limit can fall on the same clock, when the synchronized lock pattern reaches the sequencer on its final allowed sample. The bench sweeps the lock arrival time across every edge from reset up to past the limit. This places lock on the last sample, and also one sample too late. The outcome is judged by which flag rises, the edge on which it rises, and the final main image word.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [2:0] {
    ST_PARAM  = 3'd0,
    ST_LPSET  = 3'd1,
    ST_DLLON  = 3'd2,
    ST_DLLGO  = 3'd3,
    ST_POLL   = 3'd4,
    ST_FORCED = 3'd5,
    ST_LOCKED = 3'd6,
    ST_FAIL   = 3'd7
  } seq_st_e;

  localparam int unsigned CTL_W      = 32;
  localparam int unsigned LOCK_W     = 3;
  localparam int unsigned CODE_LO    = 6;
  localparam int unsigned CODE_HI    = 13;
  localparam int unsigned CODE_W     = CODE_HI - CODE_LO + 1;
  localparam int unsigned CODE_SHIFT = 18;
  localparam int unsigned CODE_DST   = CODE_LO + CODE_SHIFT;

  localparam logic [CTL_W-1:0] CTL0_PARAM = 32'h0010_1000;
  localparam logic [CTL_W-1:0] CTL1_LPDDR = 32'h0000_0086;
  localparam logic [CTL_W-1:0] BIT_DLL_ON = 32'h0000_0002;
  localparam logic [CTL_W-1:0] BIT_DLL_GO = 32'h0000_0001;

  function automatic logic [CTL_W-1:0] force_word(input logic [CODE_W-1:0] code);
    logic [CTL_W-1:0] w;
    w = '0;
    w[CODE_DST +: CODE_W] = code;
    return w | CTL0_PARAM | BIT_DLL_ON | BIT_DLL_GO;
  endfunction

endpackage

// File: rtl/dls_sync.sv
module dls_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/dls_timer.sv
module dls_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | en;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/dls_fsm.sv
module dls_fsm
  import dls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_ok,
  input  logic [CODE_W-1:0] code,
  input  logic              tmr_last,
  output logic              tmr_clr,
  output logic              tmr_en,
  output logic [CTL_W-1:0]  ctl0,
  output logic [CTL_W-1:0]  ctl1,
  output logic              done,
  output logic              err
);
  seq_st_e          st_q, st_d;
  logic [CTL_W-1:0] ctl0_q, ctl0_d;
  logic [CTL_W-1:0] ctl1_q;
  logic             ctl0_en, ctl1_en;
  logic             done_q, done_set;
  logic             err_q, err_set;

  always_comb begin
    st_d     = st_q;
    ctl0_d   = ctl0_q;
    ctl0_en  = 1'b0;
    ctl1_en  = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    unique case (st_q)
      ST_PARAM: begin
        ctl0_d  = CTL0_PARAM;
        ctl0_en = 1'b1;
        st_d    = ST_LPSET;
      end
      ST_LPSET: begin
        ctl1_en = 1'b1;
        st_d    = ST_DLLON;
      end
      ST_DLLON: begin
        ctl0_d  = CTL0_PARAM | BIT_DLL_ON;
        ctl0_en = 1'b1;
        st_d    = ST_DLLGO;
      end
      ST_DLLGO: begin
        ctl0_d  = CTL0_PARAM | BIT_DLL_ON | BIT_DLL_GO;
        ctl0_en = 1'b1;
        tmr_clr = 1'b1;
        st_d    = ST_POLL;
      end
      ST_POLL: begin
        if (lock_ok) begin
          ctl0_d  = force_word(code);
          ctl0_en = 1'b1;
          st_d    = ST_FORCED;
        end else if (tmr_last) begin
          err_set = 1'b1;
          st_d    = ST_FAIL;
        end else begin
          tmr_en  = 1'b1;
        end
      end
      ST_FORCED: begin
        done_set = 1'b1;
        st_d     = ST_LOCKED;
      end
      ST_LOCKED: st_d = ST_LOCKED;
      ST_FAIL:   st_d = ST_FAIL;
      default:   st_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PARAM;
      ctl0_q <= '0;
      ctl1_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ctl0_en)  ctl0_q <= ctl0_d;
      if (ctl1_en)  ctl1_q <= CTL1_LPDDR;
      if (done_set) done_q <= 1'b1;
      if (err_set)  err_q  <= 1'b1;
    end
  end

  assign ctl0 = ctl0_q;
  assign ctl1 = ctl1_q;
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dls_pkg::*;
#(
  parameter int unsigned STAT_W     = 16,
  parameter int unsigned LOCK_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] dll_status,
  output logic [31:0]       ctl0_img,
  output logic [31:0]       ctl1_img,
  output logic              done,
  output logic              timeout_err
);
  logic [STAT_W-1:0] stat_s;
  logic              lock_ok;
  logic [CODE_W-1:0] code;
  logic              tmr_clr, tmr_en, tmr_last;
  logic              unused_stat_bits;

  dls_sync #(.W(STAT_W)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (dll_status),
    .d_sync  (stat_s)
  );

  assign lock_ok = &stat_s[LOCK_W-1:0];
  assign code    = stat_s[CODE_HI:CODE_LO];

  generate
    if (STAT_W > CODE_HI + 1) begin : g_hi_unused
      assign unused_stat_bits = ^{stat_s[STAT_W-1:CODE_HI+1], stat_s[CODE_LO-1:LOCK_W]};
    end else begin : g_hi_none
      assign unused_stat_bits = ^stat_s[CODE_LO-1:LOCK_W];
    end
  endgenerate

  dls_timer #(.LIMIT(LOCK_LIMIT)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .last  (tmr_last)
  );

  dls_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_ok  (lock_ok),
    .code     (code),
    .tmr_last (tmr_last),
    .tmr_clr  (tmr_clr),
    .tmr_en   (tmr_en),
    .ctl0     (ctl0_img),
    .ctl1     (ctl1_img),
    .done     (done),
    .err      (timeout_err)
  );
endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl0_img,
  input logic [31:0] ctl1_img,
  input logic        done,
  input logic        timeout_err
);
  // R3
  aux_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_img == 32'h0) || (ctl1_img == 32'h86));

  // R7
  force_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($stable(ctl0_img) && ctl0_img[1:0] == 2'b11
                     && ctl0_img[20] && ctl0_img[12] && ctl0_img[23:21] == 3'b000));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(ctl0_img));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> (timeout_err && !done && ctl0_img == 32'h0010_1003));

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout_err}));
endmodule

bind dll_lock_seq dll_lock_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl0_img    (ctl0_img),
  .ctl1_img    (ctl1_img),
  .done        (done),
  .timeout_err (timeout_err)
);

// File: tb/dll_lock_seq_tb_top.sv
module dll_lock_seq_tb_top;
  localparam int STAT_W = 16;
  localparam int L      = 8;

  logic              clk;
  logic              rst_n;
  logic [STAT_W-1:0] dll_status;
  logic [31:0]       ctl0_img, ctl1_img;
  logic              done, timeout_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int ecnt  = 0;

  dll_lock_seq #(.STAT_W(STAT_W), .LOCK_LIMIT(L)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dll_status  (dll_status),
    .ctl0_img    (ctl0_img),
    .ctl1_img    (ctl1_img),
    .done        (done),
    .timeout_err (timeout_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // t_lock: edge count from which the lock word is driven
  task automatic run_trial(input int t_lock, input logic [7:0] code, input logic [2:0] part);
    logic [15:0] lock_w, part_w;
    int k, done_edge, err_edge;
    logic [31:0] exp_force, base;
    lock_w    = 16'hC038 | (16'(code) << 6) | 16'h0007;
    part_w    = 16'h8028 | (16'(~code) << 6) | 16'(part);
    base      = 32'h0010_1003;
    exp_force = {code, 24'h0} | base;
    done_edge = -1;
    err_edge  = -1;
    rst_n      = 1'b0;
    dll_status = part_w;
    repeat (2) @(negedge clk);
    chk("R1 ctl0 reset", ctl0_img, 32'h0);
    chk("R1 ctl1 reset", ctl1_img, 32'h0);
    chk("R1 flags reset", {30'h0, done, timeout_err}, 32'h0);
    rst_n      = 1'b1;
    dll_status = (t_lock == 0) ? lock_w : part_w;
    for (int i = 1; i <= L + 20; i++) begin
      @(negedge clk);
      if (ecnt == 1) chk("R2 param word", ctl0_img, 32'h0010_1000);
      if (ecnt == 2) chk("R3 aux word", ctl1_img, 32'h86);
      if (ecnt == 3) chk("R4 dll on", ctl0_img, 32'h0010_1002);
      if (ecnt == 4) chk("R5 dll start", ctl0_img, 32'h0010_1003);
      if (done && done_edge < 0)       done_edge = ecnt;
      if (timeout_err && err_edge < 0) err_edge  = ecnt;
      dll_status = (ecnt >= t_lock) ? lock_w : part_w;
    end
    k = (t_lock > 2) ? t_lock - 2 : 0;
    if (k <= L - 1) begin
      chk("R7 forced word", ctl0_img, exp_force);
      chk("R8 done edge", 32'(done_edge), 32'(6 + k));
      chk("R6 lock timing", 32'(done_edge - 1), 32'(t_lock > 2 ? t_lock + 3 : 5));
      if (k == L - 1) chk("R10 last sample wins", {31'h0, timeout_err}, 32'h0);
      lock_w = lock_w ^ 16'h3FC0;
      part_w = 16'h0;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        dll_status = (j % 2 == 0) ? lock_w : part_w;
      end
      chk("R8 frozen after done", ctl0_img, exp_force);
      chk("R8 done held", {31'h0, done}, 32'h1);
    end else begin
      chk("R9 timeout edge", 32'(err_edge), 32'(L + 4));
      chk("R9 no done", {31'h0, done}, 32'h0);
      chk("R9 word held", ctl0_img, base);
    end
    chk("R3 aux held", ctl1_img, 32'h86);
  endtask

  initial begin
    rst_n      = 1'b0;
    dll_status = '0;
    // sweep lock arrival over every edge through past the limit (R6, R9, R10)
    for (int t = 0; t <= L + 5; t++) begin
      run_trial(t, 8'(8'h5A + 8'(t * 37)), 3'(t % 7));
    end
    // near-lock patterns never accepted (R6)
    for (int p = 0; p < 7; p++) begin
      run_trial(1000, 8'hFF, 3'(p));
    end
    // code extremes (R7)
    run_trial(3, 8'h00, 3'd6);
    run_trial(3, 8'hFF, 3'd5);
    run_trial(3, 8'h81, 3'd3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule